// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flag-Tagged Queue

This block is the receive side of an asynchronous serial port. It watches the incoming line using a clock enable that pulses sixteen times per bit. It rebuilds each character using a programmable format. That format selects 7 or 8 data bits, no parity, even parity or odd parity, and one or two stop bits.

Every received character goes into a 12-entry queue. Each entry carries its own framing, parity and overrun flags. A host pops entries through a simple read port. The block raises the following conditions for the host:

- an error indication, when a flagged entry is close to the read side;
- a service request, based on the queue level;
- sticky events for the start and the end of a break;
- a sticky idle event, when characters wait while the line stays quiet.

Baud-rate generation, DMA and modem lines are handled elsewhere.

Top module: `uart_rx_tagged`

## Requirements
- R1: A bit value is taken on the eighth oversampling tick of the start bit and every sixteenth tick after that. A low level seen at the start is accepted only if the line is still low at that mid-bit sample; a shorter low pulse stores nothing.
- R2: The format follows `cfg_data8` (1 = 8 data bits, 0 = 7), `cfg_par_en`, `cfg_par_odd` (1 = odd, 0 = even) and `cfg_stop2` (1 = two stop bits). Data arrives least significant bit first. In 7-bit mode, bit 7 of the stored data is 0.
- R3: Each entry reads as `rd_data[7:0]` data, `[8]` framing error (a stop bit sampled low), `[9]` parity error and `[10]` overrun. Entries come out oldest first. The head is visible while `rd_valid` is 1, and a cycle with `rd_pop` high removes it. `rd_fill` gives the entry count, which is at most 12.
- R4: If a character completes while the queue holds 12 entries and no pop occurs in that cycle, the character is discarded, bit 10 of the newest stored entry is set, and `rd_fill` stays 12.
- R5: `err_irq` is 1 exactly when one of the four oldest stored entries has bit 8, 9 or 10 set.
- R6: `svc_req` is 1 when `rd_fill` is 4 or more, and 0 below 4.
- R7: A frame whose data bits and stop bits are all sampled low is a break. It sets `brk_begin_flag` and stores no entry.
- R8: After a break, the line returning high sets `brk_end_flag`.
- R9: `idle_flag` is set once the receiver is idle, the line is high and the queue is non-empty for three frame periods. A frame period is 16 ticks times the frame bit count (start, data, parity and stop bits).
- R10: The sticky flags are cleared by writing a one to `flag_clr`: bit 0 clears break begin, bit 1 clears break end, bit 2 clears idle. A flag that is set and not cleared holds its value.
- R11: After reset the queue is empty and all flags and requests are 0. While `rx_enable` is 0, the receiver stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receiver enable |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| cfg_data8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | Two stop bits |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 11 | Head entry: overrun, parity error, framing error, data |
| rd_valid | output | 1 | Queue not empty |
| rd_fill | output | 4 | Number of stored entries |
| svc_req | output | 1 | Queue level service request |
| err_irq | output | 1 | Flagged entry among the four oldest |
| brk_begin_flag | output | 1 | Sticky break-start event |
| brk_end_flag | output | 1 | Sticky break-end event |
| idle_flag | output | 1 | Sticky idle-timeout event |
| flag_clr | input | 3 | Write-one-to-clear for the three sticky flags |

## Verification
The hardest situation to reach is the exact edge of the error window. A flagged character has to sit at queue position five and then move to position four. The stimulus first fills the queue with five clean characters, then sends one with a bad parity bit. It then pops one entry at a time and checks `err_irq` after each pop.

Overrun is reached by stopping the consumer and sending a thirteenth character. The scoreboard expects the overrun bit on the twelfth entry and never sees the thirteenth. The idle timeout is bracketed by sampling the flag at about two and about four frame periods after the last character.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_WAIT
    } rx_state_e;

    typedef struct packed {
        logic              oe;
        logic              pe;
        logic              fe;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
    import urx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      tick,
    input  logic      rxd,
    input  logic      cfg_data8,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic      cfg_stop2,
    output logic      push,
    output rx_entry_t push_entry,
    output logic      brk_b,
    output logic      brk_e,
    output logic      line_idle
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [2:0]        bitn;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              pe;
        logic              fe;
        logic              zero;
        logic [1:0]        sync;
        logic              push;
        logic              brk_b;
        logic              brk_e;
    } smp_t;

    smp_t q, d;
    logic rx, at_mid, at_bit, fe_now, zero_now;
    logic [2:0] last_bit;

    always_comb begin
        d          = q;
        d.push     = 1'b0;
        d.brk_b    = 1'b0;
        d.brk_e    = 1'b0;
        d.sync     = {q.sync[0], rxd};
        rx         = q.sync[1];
        at_mid     = tick && (q.cnt == CW'(MID - 1));
        at_bit     = tick && (q.cnt == CW'(OSR - 1));
        last_bit   = cfg_data8 ? 3'd7 : 3'd6;
        fe_now     = q.fe | ~rx;
        zero_now   = q.zero & ~rx;
        if (!enable) begin
            d.st  = S_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                S_IDLE: if (tick && !rx) begin
                    d.st  = S_START;
                    d.cnt = '0;
                end
                S_START: if (at_mid) begin
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.sh   = '0;
                    d.par  = 1'b0;
                    d.pe   = 1'b0;
                    d.fe   = 1'b0;
                    d.zero = 1'b1;
                    d.st   = rx ? S_IDLE : S_DATA;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
                S_DATA: if (at_bit) begin
                    d.cnt         = '0;
                    d.sh[q.bitn]  = rx;
                    d.par         = q.par ^ rx;
                    d.zero        = zero_now;
                    if (q.bitn == last_bit) begin
                        d.bitn = '0;
                        d.st   = cfg_par_en ? S_PAR : S_STOP;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
                S_PAR: if (at_bit) begin
                    d.cnt = '0;
                    d.pe  = (q.par ^ rx) != cfg_par_odd;
                    d.st  = S_STOP;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
                S_STOP: if (at_bit) begin
                    d.cnt  = '0;
                    d.fe   = fe_now;
                    d.zero = zero_now;
                    if (cfg_stop2 && q.bitn == 3'd0) begin
                        d.bitn = 3'd1;
                    end else if (zero_now) begin
                        d.brk_b = 1'b1;
                        d.st    = S_BRK;
                    end else begin
                        d.push = 1'b1;
                        d.st   = rx ? S_IDLE : S_WAIT;
                    end
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
                S_BRK: if (rx) begin
                    d.brk_e = 1'b1;
                    d.st    = S_IDLE;
                end
                S_WAIT: if (rx) d.st = S_IDLE;
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign push       = q.push;
    assign push_entry = '{oe: 1'b0, pe: q.pe, fe: q.fe, data: q.sh};
    assign brk_b      = q.brk_b;
    assign brk_e      = q.brk_e;
    assign line_idle  = (q.st == S_IDLE) && q.sync[1];

    assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.push, q.brk_b, q.brk_e}));
    assert_break_not_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.brk_b |-> !q.push);
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !q.push);
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int WIN   = 4,
    parameter int LVL   = DEPTH / 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_entry_t                  din,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic                       nonempty,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       level_hit,
    output logic                       err_hit
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t q, d;
    logic pop_ok, full, wr_ok, err;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        d      = q;
        full   = (q.cnt == CW'(DEPTH));
        pop_ok = pop && (q.cnt != '0);
        wr_ok  = push && (!full || pop_ok);
        if (pop_ok) d.rd = nxt(q.rd);
        if (wr_ok) begin
            d.mem[q.wr] = din;
            d.wr        = nxt(q.wr);
        end else if (push) begin
            d.mem[prv(q.wr)].oe = 1'b1;
        end
        d.cnt = q.cnt + CW'(wr_ok) - CW'(pop_ok);

        err = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            int k;
            k = int'(q.rd) + i;
            if (k >= DEPTH) k = k - DEPTH;
            if (i < int'(q.cnt)) begin
                err = err | q.mem[PW'(k)].fe | q.mem[PW'(k)].pe | q.mem[PW'(k)].oe;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head      = q.mem[q.rd];
    assign nonempty  = (q.cnt != '0);
    assign fill      = q.cnt;
    assign level_hit = (q.cnt >= CW'(LVL));
    assign err_hit   = err;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q.cnt == CW'(DEPTH) && !pop) |=> q.cnt == CW'(DEPTH));
    assert_err_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |-> nonempty);
endmodule

// File: rtl/urx_events.sv
module urx_events #(
    parameter int OSR         = 16,
    parameter int IDLE_FRAMES = 3,
    parameter int MAX_BITS    = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       brk_b,
    input  logic       brk_e,
    input  logic       line_idle,
    input  logic       q_nonempty,
    input  logic       cfg_data8,
    input  logic       cfg_par_en,
    input  logic       cfg_stop2,
    input  logic [2:0] clr,
    output logic [2:0] flags
);
    localparam int LIM_MAX = IDLE_FRAMES * OSR * MAX_BITS;
    localparam int TW      = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [2:0]    st;
    } ev_t;

    ev_t q, d;
    logic [3:0]    bits;
    logic [TW-1:0] lim;
    logic [2:0]    set;
    logic          quiet;

    always_comb begin
        d     = q;
        bits  = 4'd2 + (cfg_data8 ? 4'd8 : 4'd7) + {3'd0, cfg_par_en} + {3'd0, cfg_stop2};
        lim   = TW'(IDLE_FRAMES * OSR) * TW'(bits);
        quiet = line_idle && q_nonempty;
        set   = {1'b0, brk_e, brk_b};
        if (!quiet) begin
            d.cnt = '0;
        end else if (tick && q.cnt < lim) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == lim - 1'b1) set[2] = 1'b1;
        end
        d.st = (q.st & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags = q.st;

    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[2] && !(quiet && tick)) |=> !q.st[2]);
    assert_brk_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st[0] && !clr[0]) |=> q.st[0]);
    assert_idle_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st[2]) |-> $past(q_nonempty));
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import urx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 12,
    parameter int WIN   = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int EW   = $bits(rx_entry_t)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic          cfg_data8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic          rd_pop,
    output logic [EW-1:0] rd_data,
    output logic          rd_valid,
    output logic [CW-1:0] rd_fill,
    output logic          svc_req,
    output logic          err_irq,
    output logic          brk_begin_flag,
    output logic          brk_end_flag,
    output logic          idle_flag,
    input  logic [2:0]    flag_clr
);
    logic      push, brk_b, brk_e, line_idle;
    rx_entry_t push_entry, head;
    logic [2:0] flags;

    urx_sampler #(.OSR(OSR)) u_smp (
        .clk(clk), .rst_n(rst_n), .enable(rx_enable), .tick(os_tick), .rxd(rxd),
        .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .push(push), .push_entry(push_entry),
        .brk_b(brk_b), .brk_e(brk_e), .line_idle(line_idle)
    );

    urx_fifo #(.DEPTH(DEPTH), .WIN(WIN)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_entry), .pop(rd_pop),
        .head(head), .nonempty(rd_valid), .fill(rd_fill),
        .level_hit(svc_req), .err_hit(err_irq)
    );

    urx_events #(.OSR(OSR)) u_ev (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .brk_b(brk_b), .brk_e(brk_e),
        .line_idle(line_idle), .q_nonempty(rd_valid), .cfg_data8(cfg_data8),
        .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2), .clr(flag_clr), .flags(flags)
    );

    assign rd_data        = head;
    assign brk_begin_flag = flags[0];
    assign brk_end_flag   = flags[1];
    assign idle_flag      = flags[2];

    assert_req_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> rd_valid);
    assert_seven_bit_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !cfg_data8) |-> !push_entry.data[7]);
endmodule

// File: tb/uart_rx_tagged_bench.sv
module uart_rx_tagged_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;
    localparam int BIT_CLKS   = 16 * TDIV;

    logic clk = 1'b0, rst_n = 1'b0, rx_enable = 1'b0, os_tick = 1'b0, rxd = 1'b1;
    logic cfg_data8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic rd_pop = 1'b0;
    logic [2:0] flag_clr = 3'b000;
    logic [10:0] rd_data;
    logic [3:0]  rd_fill;
    logic rd_valid, svc_req, err_irq, brk_begin_flag, brk_end_flag, idle_flag;

    int checks = 0, failures = 0, pop_budget = 0;
    logic [10:0] exp_q[$];

    uart_rx_tagged u_uart_rx_tagged (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .os_tick(os_tick), .rxd(rxd),
        .cfg_data8(cfg_data8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_fill(rd_fill), .svc_req(svc_req), .err_irq(err_irq),
        .brk_begin_flag(brk_begin_flag), .brk_end_flag(brk_end_flag),
        .idle_flag(idle_flag), .flag_clr(flag_clr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            os_tick = (c == 0);
            c = (c == TDIV - 1) ? 0 : c + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pops while a budget remains, compares with the queue
    initial begin : monitor
        forever begin
            @(negedge clk);
            rd_pop = 1'b0;
            if (pop_budget > 0 && rd_valid) begin
                if (exp_q.size() == 0) check("R3 unexpected entry", {21'd0, rd_data}, 32'h7ff);
                else check("R3 scoreboard entry", {21'd0, rd_data}, {21'd0, exp_q.pop_front()});
                rd_pop = 1'b1;
                pop_budget--;
            end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        wait_clks(BIT_CLKS);
    endtask

    task automatic send_frame(input logic [7:0] dat, input bit bad_par, input bit bad_stop,
                              input bit expect_it);
        int nb;
        logic p;
        logic [7:0] m;
        nb = cfg_data8 ? 8 : 7;
        m  = cfg_data8 ? dat : {1'b0, dat[6:0]};
        p  = 1'b0;
        if (expect_it) exp_q.push_back({1'b0, bad_par & cfg_par_en, bad_stop, m});
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(dat[i]);
            p = p ^ dat[i];
        end
        if (cfg_par_en) drive_bit((cfg_par_odd ? ~p : p) ^ bad_par);
        drive_bit(!bad_stop);
        if (cfg_stop2) drive_bit(!bad_stop);
        drive_bit(1'b1);
    endtask

    task automatic drain();
        pop_budget = 1000;
        for (int i = 0; i < 200 && rd_valid; i++) wait_clks(1);
        wait_clks(2);
        pop_budget = 0;
        check("R3 scoreboard drained", exp_q.size(), 0);
        check("R3 fill after drain", {28'd0, rd_fill}, 0);
    endtask

    task automatic pop_n(input int n);
        pop_budget = n;
        for (int i = 0; i < 100 && pop_budget > 0; i++) wait_clks(1);
        wait_clks(2);
    endtask

    task automatic clear_flags(input logic [2:0] m);
        flag_clr = m;
        wait_clks(1);
        flag_clr = 3'b000;
        wait_clks(1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        // R11 reset state
        check("R11 fill after reset", {28'd0, rd_fill}, 0);
        check("R11 valid after reset", {31'd0, rd_valid}, 0);
        check("R11 outputs after reset",
              {27'd0, svc_req, err_irq, brk_begin_flag, brk_end_flag, idle_flag}, 0);

        // R11 disabled receiver stores nothing
        send_frame(8'h81, 0, 0, 0);
        check("R11 disabled fill", {28'd0, rd_fill}, 0);
        rx_enable = 1'b1;
        wait_clks(4);

        // R1 R3 basic 8N1 traffic through the scoreboard
        pop_budget = 1000;
        send_frame(8'h55, 0, 0, 1);
        send_frame(8'hA3, 0, 0, 1);
        send_frame(8'h01, 0, 0, 1);
        send_frame(8'hFE, 0, 0, 1);
        drain();

        // R1 short low pulse is rejected
        rxd = 1'b0;
        wait_clks(2 * TDIV);
        rxd = 1'b1;
        wait_clks(3 * BIT_CLKS);
        check("R1 glitch stores nothing", {28'd0, rd_fill}, 0);

        // R2 seven bits, odd parity, two stops
        cfg_data8 = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
        pop_budget = 1000;
        send_frame(8'h5A, 0, 0, 1);
        send_frame(8'hC3, 0, 0, 1);
        send_frame(8'h2B, 1, 0, 1);
        drain();

        // R2 R3 eight bits even parity: parity and framing flags
        cfg_data8 = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
        pop_budget = 1000;
        send_frame(8'h96, 0, 0, 1);
        send_frame(8'h96, 1, 0, 1);
        send_frame(8'h3C, 0, 1, 1);
        send_frame(8'h77, 0, 0, 1);
        drain();

        // R6 level and R5 window edge
        send_frame(8'h10, 0, 0, 1);
        send_frame(8'h11, 0, 0, 1);
        send_frame(8'h12, 0, 0, 1);
        check("R6 three entries no request", {31'd0, svc_req}, 0);
        send_frame(8'h13, 0, 0, 1);
        check("R6 four entries request", {31'd0, svc_req}, 1);
        send_frame(8'h14, 0, 0, 1);
        send_frame(8'h15, 1, 0, 1);
        check("R5 flag at position six", {31'd0, err_irq}, 0);
        pop_n(1);
        check("R5 flag at position five", {31'd0, err_irq}, 0);
        pop_n(1);
        check("R5 flag at position four", {31'd0, err_irq}, 1);
        drain();
        check("R5 empty no error", {31'd0, err_irq}, 0);

        // R4 overrun
        cfg_par_en = 1'b0;
        for (int i = 0; i < 12; i++) send_frame(8'(8'h40 + i), 0, 0, 1);
        check("R4 full fill", {28'd0, rd_fill}, 12);
        send_frame(8'hEE, 0, 0, 0);
        begin
            logic [10:0] t;
            t = exp_q[11];
            t[10] = 1'b1;
            exp_q[11] = t;
        end
        check("R4 fill after overrun", {28'd0, rd_fill}, 12);
        check("R5 overrun on newest outside window", {31'd0, err_irq}, 0);
        drain();

        // R7 R8 break
        clear_flags(3'b111);
        rxd = 1'b0;
        wait_clks(12 * BIT_CLKS);
        check("R7 break begin", {31'd0, brk_begin_flag}, 1);
        check("R8 no end while low", {31'd0, brk_end_flag}, 0);
        check("R7 break not stored", {28'd0, rd_fill}, 0);
        rxd = 1'b1;
        wait_clks(8);
        check("R8 break end", {31'd0, brk_end_flag}, 1);
        wait_clks(BIT_CLKS);
        check("R10 flags hold", {30'd0, brk_end_flag, brk_begin_flag}, 2'b11);
        clear_flags(3'b001);
        check("R10 clear begin only", {30'd0, brk_end_flag, brk_begin_flag}, 2'b10);
        clear_flags(3'b010);
        check("R10 clear end", {31'd0, brk_end_flag}, 0);

        // R9 idle timeout (8N1 frame period = 160 ticks)
        send_frame(8'h5C, 0, 0, 1);
        clear_flags(3'b100);
        wait_clks(1100);
        check("R9 no idle before three frames", {31'd0, idle_flag}, 0);
        wait_clks(1300);
        check("R9 idle after three frames", {31'd0, idle_flag}, 1);
        clear_flags(3'b100);
        check("R10 idle cleared", {31'd0, idle_flag}, 0);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule